// File: doc/BRIEF.md
# Double-Buffered PWM Compare Register Bank

This block holds the compare values of a three-phase PWM timer and runs its triangle carrier. A 16-bit up/down counter climbs from zero to the period value and falls back to zero, over and over, while a run bit is set. The active period value and three phase compare values are checked against the counter every cycle. Each check raises a one-cycle match flag when the counter equals the value it is checked against.

Software writes new compare values through a write-only register bus. The bus has an address, write data, a two-bit byte-enable mask and a write strobe. Each phase value and the period value sit behind a shadow register that has two addresses. A write to the buffered address fills the shadow only. The active register then takes the shadow value at a carrier event picked by a two-bit transfer mode: the crest, the trough, both, or never. A write to the free address loads both the shadow and the active register at once. A separate dead-time register, with no shadow, holds the non-overlap interval that a later gate-drive stage reads.

Top module: `pwm_cmp_bank`

## Requirements
- R1: A full write to a phase buffered address (4, 5, 6 for phases 0, 1, 2) changes that phase's shadow only. The active compare value stays the same until a transfer event.
- R2: A full write to a phase free address (8, 9, 10 for phases 0, 1, 2) loads both the shadow and the active value. The new value shows on `activeCmp` one clock after the write.
- R3: Only writes with `busBe` equal to 2'b11 have any effect. A write with any other mask leaves every register and the run/mode state unchanged.
- R4: The control register is at address 0: bit 0 is run and bits 2:1 are the transfer mode. Mode 00 never transfers. Mode 01 transfers in a running cycle where the counter equals the active period. Mode 10 transfers in a running cycle where the counter is 0. Mode 11 transfers at both. A transfer copies every phase shadow and the period buffer (address 2) into the active registers. Address 3 loads the period buffer and the active period at once.
- R5: While run is set, the counter steps by one each cycle. It counts up until it reaches the active period, then counts down to 0, then counts up again. An active period of 0 holds the counter at 0. While run is clear, the counter holds its value.
- R6: `periodMatch` is high in exactly those cycles where run is set and the counter equals the active period.
- R7: `phaseMatch[i]` is high in exactly those cycles where run is set and the counter equals phase i's active compare value.
- R8: A full write to address 1 loads `deadTime` directly. The new value shows one clock later.
- R9: When a buffered write and a transfer event fall in the same cycle, the active register takes the new write data.
- R10: After reset all registers, the counter, run and mode are zero, and every match flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Register address |
| busWdata | input | 16 | Write data |
| busBe | input | 2 | Byte enables; must be all ones for a write to take effect |
| busWrite | input | 1 | Write strobe |
| carrier | output | 16 | Carrier counter value |
| periodMatch | output | 1 | Counter equals active period while running |
| phaseMatch | output | 3 | Per-phase compare match |
| activeCmp | output | 48 | Active compare values, phase i in bits 16i+15:16i |
| periodVal | output | 16 | Active period value |
| deadTime | output | 16 | Dead-time interval |

## Verification
Every register output (`activeCmp`, `periodVal`, `deadTime`, `carrier`) changes at the clock edge that samples a write or a transfer event, so it is due one cycle after the stimulus. The match flags are combinational from those registers and are due in the same cycle as the counter value that causes them. The bench keeps a cycle model that advances on the rising edge and drives the bus on the falling edge. It compares every output on the falling edge, half a cycle after the edge that produced it. The coincident-write case is timed by driving the write on the falling edge just before the edge at which the model shows a crest.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int NPH    = 3;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_DEAD     = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_PER_BUF  = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_PER_FREE = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_PH_BUF0  = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_PH_FREE0 = 4'd8;

  // strobes from control to datapath
  typedef struct packed {
    logic           deadWr;
    logic           perBufWr;
    logic           perFreeWr;
    logic [NPH-1:0] phBufWr;
    logic [NPH-1:0] phFreeWr;
    logic           xferNow;
    logic           counting;
  } bank_strb_t;
endpackage

// File: rtl/pwm_bank_ctrl.sv
module pwm_bank_ctrl
  import pwm_bank_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [DATA_W/8-1:0]      busBe,
  input  logic                     busWrite,
  input  logic [2:0]               ctrlBits,
  input  logic [DATA_W-1:0]        periodCmp,
  output bank_strb_t               strb,
  output logic [DATA_W-1:0]        carrier,
  output logic                     periodMatch
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic              fullWr;
  logic              runBit;
  logic [1:0]        xferMode;
  logic [DATA_W-1:0] cnt, cntNext;
  logic              dirDown, dirNext;
  logic              crestHit, troughHit;

  assign fullWr = busWrite && (&busBe);

  assign strb.deadWr    = fullWr && (busAddr == ADDR_DEAD);
  assign strb.perBufWr  = fullWr && (busAddr == ADDR_PER_BUF);
  assign strb.perFreeWr = fullWr && (busAddr == ADDR_PER_FREE);

  for (genvar i = 0; i < NPH; i++) begin : g_decode
    assign strb.phBufWr[i]  = fullWr && (busAddr == ADDR_PH_BUF0  + ADDR_W'(i));
    assign strb.phFreeWr[i] = fullWr && (busAddr == ADDR_PH_FREE0 + ADDR_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit   <= 1'b0;
      xferMode <= 2'b00;
    end else if (fullWr && busAddr == ADDR_CTRL) begin
      runBit   <= ctrlBits[0];
      xferMode <= ctrlBits[2:1];
    end
  end

  assign crestHit  = runBit && (cnt == periodCmp);
  assign troughHit = runBit && (cnt == '0);

  assign strb.xferNow  = (xferMode[0] && crestHit) || (xferMode[1] && troughHit);
  assign strb.counting = runBit;

  always_comb begin
    cntNext = cnt;
    dirNext = dirDown;
    if (runBit) begin
      if (periodCmp == '0) begin
        cntNext = '0;
        dirNext = 1'b0;
      end else if (!dirDown) begin
        if (cnt >= periodCmp) begin
          dirNext = 1'b1;
          cntNext = cnt - ONE;
        end else begin
          cntNext = cnt + ONE;
        end
      end else begin
        if (cnt == '0) begin
          dirNext = 1'b0;
          cntNext = ONE;
        end else begin
          cntNext = cnt - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      dirDown <= 1'b0;
    end else begin
      cnt     <= cntNext;
      dirDown <= dirNext;
    end
  end

  assign carrier     = cnt;
  assign periodMatch = crestHit;
endmodule

// File: rtl/pwm_bank_dp.sv
module pwm_bank_dp
  import pwm_bank_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  bank_strb_t               strb,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W-1:0]        carrier,
  output logic [NPH*DATA_W-1:0]    activeCmp,
  output logic [DATA_W-1:0]        periodVal,
  output logic [DATA_W-1:0]        deadTime,
  output logic [NPH-1:0]           phaseMatch
);
  logic [DATA_W-1:0] perShadow, perActive, deadReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perShadow <= '0;
      perActive <= '0;
    end else if (strb.perFreeWr) begin
      perShadow <= wdata;
      perActive <= wdata;
    end else begin
      if (strb.perBufWr) perShadow <= wdata;
      if (strb.xferNow)  perActive <= strb.perBufWr ? wdata : perShadow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            deadReg <= '0;
    else if (strb.deadWr) deadReg <= wdata;
  end

  for (genvar i = 0; i < NPH; i++) begin : g_phase
    logic [DATA_W-1:0] phShadow, phActive;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        phShadow <= '0;
        phActive <= '0;
      end else if (strb.phFreeWr[i]) begin
        phShadow <= wdata;
        phActive <= wdata;
      end else begin
        if (strb.phBufWr[i]) phShadow <= wdata;
        if (strb.xferNow)    phActive <= strb.phBufWr[i] ? wdata : phShadow;
      end
    end

    assign activeCmp[i*DATA_W +: DATA_W] = phActive;
    assign phaseMatch[i] = strb.counting && (carrier == phActive);
  end

  assign periodVal = perActive;
  assign deadTime  = deadReg;
endmodule

// File: rtl/pwm_cmp_bank.sv
module pwm_cmp_bank
  import pwm_bank_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [DATA_W-1:0]      busWdata,
  input  logic [DATA_W/8-1:0]    busBe,
  input  logic                   busWrite,
  output logic [DATA_W-1:0]      carrier,
  output logic                   periodMatch,
  output logic [NPH-1:0]         phaseMatch,
  output logic [NPH*DATA_W-1:0]  activeCmp,
  output logic [DATA_W-1:0]      periodVal,
  output logic [DATA_W-1:0]      deadTime
);
  bank_strb_t strb;

  pwm_bank_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busBe(busBe),
    .busWrite(busWrite), .ctrlBits(busWdata[2:0]), .periodCmp(periodVal),
    .strb(strb), .carrier(carrier), .periodMatch(periodMatch)
  );

  pwm_bank_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata), .carrier(carrier),
    .activeCmp(activeCmp), .periodVal(periodVal), .deadTime(deadTime),
    .phaseMatch(phaseMatch)
  );
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_bank_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     busAddr,
  input logic [DATA_W-1:0]     busWdata,
  input logic [DATA_W/8-1:0]   busBe,
  input logic                  busWrite,
  input logic                  xferNow,
  input logic                  counting,
  input logic [DATA_W-1:0]     carrier,
  input logic [NPH*DATA_W-1:0] activeCmp,
  input logic [DATA_W-1:0]     periodVal,
  input logic [DATA_W-1:0]     deadTime
);
  assert_buf_holds_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && (&busBe) && busAddr == ADDR_PH_BUF0 && !xferNow)
      |=> $stable(activeCmp[DATA_W-1:0]));

  assert_free_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && (&busBe) && busAddr == ADDR_PH_FREE0)
      |=> activeCmp[DATA_W-1:0] == $past(busWdata));

  assert_partial_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && !(&busBe) && !xferNow)
      |=> ($stable(activeCmp) && $stable(periodVal) && $stable(deadTime)));

  assert_stopped_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    !counting |=> $stable(carrier));

  assert_unit_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    counting |=> (carrier == DATA_W'($past(carrier) + DATA_W'(1))) ||
                 (carrier == DATA_W'($past(carrier) - DATA_W'(1))) ||
                 (carrier == '0));

  assert_dead_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && (&busBe) && busAddr == ADDR_DEAD)
      |=> deadTime == $past(busWdata));
endmodule

bind pwm_cmp_bank pwm_bank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
  .busBe(busBe), .busWrite(busWrite), .xferNow(strb.xferNow),
  .counting(strb.counting), .carrier(carrier), .activeCmp(activeCmp),
  .periodVal(periodVal), .deadTime(deadTime)
);

// File: tb/pwm_cmp_bank_bench.sv
`timescale 1ns/1ps
module pwm_cmp_bank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [1:0]  busBe = '0;
  logic        busWrite = 1'b0;
  logic [15:0] carrier;
  logic        periodMatch;
  logic [2:0]  phaseMatch;
  logic [47:0] activeCmp;
  logic [15:0] periodVal;
  logic [15:0] deadTime;

  int checks = 0;
  int errors = 0;
  bit cmpOn  = 1'b0;

  always #10 clk = ~clk;

  pwm_cmp_bank u_pwm_cmp_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busBe(busBe), .busWrite(busWrite), .carrier(carrier),
    .periodMatch(periodMatch), .phaseMatch(phaseMatch),
    .activeCmp(activeCmp), .periodVal(periodVal), .deadTime(deadTime)
  );

  // cycle model built from the requirements
  logic [15:0] mCnt, mPer, mPerBuf, mDead;
  logic [15:0] mBuf [3];
  logic [15:0] mAct [3];
  logic        mDir, mRun;
  logic [1:0]  mMode;

  always @(posedge clk) begin
    logic crest, trough, xfer, full;
    logic [15:0] nCnt, nPer, nPerBuf, nDead;
    logic [15:0] nBuf [3];
    logic [15:0] nAct [3];
    logic nDir, nRun;
    logic [1:0] nMode;
    if (!rstN) begin
      mCnt = 0; mPer = 0; mPerBuf = 0; mDead = 0; mDir = 0; mRun = 0; mMode = 0;
      for (int i = 0; i < 3; i++) begin mBuf[i] = 0; mAct[i] = 0; end
    end else begin
      crest  = mRun && mCnt == mPer;
      trough = mRun && mCnt == 0;
      xfer   = (mMode[0] && crest) || (mMode[1] && trough);
      full   = busWrite && busBe == 2'b11;
      nCnt = mCnt; nDir = mDir; nPer = mPer; nPerBuf = mPerBuf; nDead = mDead;
      nRun = mRun; nMode = mMode;
      for (int i = 0; i < 3; i++) begin nBuf[i] = mBuf[i]; nAct[i] = mAct[i]; end
      if (mRun) begin
        if (mPer == 0) begin nCnt = 0; nDir = 0; end
        else if (!mDir) begin
          if (mCnt >= mPer) begin nDir = 1; nCnt = mCnt - 1; end
          else nCnt = mCnt + 1;
        end else begin
          if (mCnt == 0) begin nDir = 0; nCnt = 1; end
          else nCnt = mCnt - 1;
        end
      end
      if (xfer) begin
        nPer = mPerBuf;
        for (int i = 0; i < 3; i++) nAct[i] = mBuf[i];
      end
      if (full) begin
        case (busAddr)
          4'd0: begin nRun = busWdata[0]; nMode = busWdata[2:1]; end
          4'd1: nDead = busWdata;
          4'd2: begin nPerBuf = busWdata; if (xfer) nPer = busWdata; end
          4'd3: begin nPerBuf = busWdata; nPer = busWdata; end
          4'd4, 4'd5, 4'd6: begin
            nBuf[busAddr-4] = busWdata;
            if (xfer) nAct[busAddr-4] = busWdata;
          end
          4'd8, 4'd9, 4'd10: begin
            nBuf[busAddr-8] = busWdata;
            nAct[busAddr-8] = busWdata;
          end
          default: ;
        endcase
      end
      mCnt = nCnt; mDir = nDir; mPer = nPer; mPerBuf = nPerBuf; mDead = nDead;
      mRun = nRun; mMode = nMode;
      for (int i = 0; i < 3; i++) begin mBuf[i] = nBuf[i]; mAct[i] = nAct[i]; end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && cmpOn) begin
      chk("R5 carrier", carrier, mCnt);
      chk("R6 periodMatch", periodMatch, mRun && mCnt == mPer);
      for (int i = 0; i < 3; i++) begin
        chk("R7 phaseMatch", phaseMatch[i], mRun && mCnt == mAct[i]);
        chk("R4 activeCmp", activeCmp[i*16 +: 16], mAct[i]);
      end
      chk("R4 periodVal", periodVal, mPer);
      chk("R8 deadTime", deadTime, mDead);
    end
  end

  // called on a falling edge; returns on the next falling edge
  task automatic busWr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be);
    busAddr = a; busWdata = d; busBe = be; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; busBe = 2'b00;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [15:0] held;
    int periods [4];
    periods = '{1, 2, 5, 7};
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 carrier", carrier, 0);
    chk("R10 activeCmp", activeCmp, 0);
    chk("R10 periodVal", periodVal, 0);
    chk("R10 deadTime", deadTime, 0);
    chk("R10 flags", {periodMatch, phaseMatch}, 0);
    rstN = 1'b1;
    @(negedge clk);
    cmpOn = 1'b1;

    // R8 direct dead-time write
    busWr(4'd1, 16'h1234, 2'b11);
    chk("R8 dead write", deadTime, 16'h1234);
    // R3 partial masks ignored
    busWr(4'd1, 16'hBEEF, 2'b01);
    busWr(4'd8, 16'hBEEF, 2'b10);
    busWr(4'd0, 16'h0001, 2'b01);
    chk("R3 dead kept", deadTime, 16'h1234);
    chk("R3 phase kept", activeCmp[15:0], 0);
    repeat (3) @(negedge clk);
    chk("R3 run stays off", carrier, 0);
    // R2 free write
    busWr(4'd8, 16'h0003, 2'b11);
    chk("R2 free load", activeCmp[15:0], 16'h0003);
    // R1 buffered write does not touch active while stopped
    busWr(4'd5, 16'h0002, 2'b11);
    chk("R1 buffered only", activeCmp[31:16], 0);

    // sweep modes and periods
    for (int md = 0; md < 4; md++) begin
      for (int k = 0; k < 4; k++) begin
        int p;
        p = periods[k];
        busWr(4'd0, 16'(md * 2 + 1), 2'b11);
        busWr(md == 0 ? 4'd3 : 4'd2, 16'(p), 2'b11);
        for (int i = 0; i < 3; i++) busWr(4'(4 + i), 16'((p * (i + 1)) / 3), 2'b11);
        repeat (4 * p + 6) @(negedge clk);
      end
    end

    // R4 mode 00 never transfers the period buffer
    busWr(4'd0, 16'h0001, 2'b11);
    held = periodVal;
    busWr(4'd2, 16'd9, 2'b11);
    repeat (20) @(negedge clk);
    chk("R4 mode00 period held", periodVal, held);

    // R9 buffered write coinciding with a crest transfer
    busWr(4'd3, 16'd4, 2'b11);
    busWr(4'd0, 16'h0003, 2'b11);
    busWr(4'd4, 16'h0033, 2'b11);
    while (!(mRun && mCnt == mPer)) @(negedge clk);
    @(negedge clk);
    while (!(mRun && mCnt == mPer)) @(negedge clk);
    busWr(4'd4, 16'h0055, 2'b11);
    chk("R9 coincident write wins", activeCmp[15:0], 16'h0055);

    // R5 stop holds the counter
    repeat (3) @(negedge clk);
    busWr(4'd0, 16'h0000, 2'b11);
    held = carrier;
    repeat (8) @(negedge clk);
    chk("R5 stopped hold", carrier, held);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule